// File: doc/BRIEF.md
# Register-Mapped General-Purpose I/O Port

This block is a general-purpose I/O port of up to 32 pins that sits on a simple synchronous register bus. Software sets each pin's direction, writes the output levels (directly or through atomic set and clear registers), reads back the synchronised pin levels, and enables interrupts per pin. A single interrupt line is raised by the pins whose mask bit is set.

The trigger mode is chosen at elaboration. It can be rising edge, falling edge, either edge or level high. In the three edge modes, qualifying edges latch into a sticky capture register. Software clears that register by writing ones to it. In level-high mode the interrupt follows the masked pin levels directly, and there is no capture. Pin inputs pass through a two-flop synchroniser before any other logic uses them.

There are no state machines. The block is built from a register file, a synchroniser stage, a capture stage selected by the trigger mode, and a combinational read multiplexer.

Top module: `pio_port`

## Requirements
- R1: After reset the output, direction, mask and capture registers are zero. pin_out, pin_oe and irq are low, and the direction, mask and capture registers read as zero.
- R2: A write to the data word (byte offset 0x00) loads pin_out on the next clock edge. A read of offset 0x00 returns the synchronised level of every pin, whatever its direction. A pin change appears there after two clock edges.
- R3: The direction word (offset 0x04) drives pin_oe. A bit of 1 makes that pin an output and a bit of 0 makes it an input.
- R4: Bits at or above PIN_COUNT read as zero and are not stored by writes.
- R5: In an edge mode, a qualifying edge sets that pin's capture bit (offset 0x0C) on the third clock edge after the pin changes. Rising mode captures 0-to-1 changes, falling mode captures 1-to-0 changes, and either-edge mode captures both.
- R6: Writing a 1 to a capture bit clears it. Writing a 0 leaves it unchanged.
- R7: If a new edge on a pin and a write of 1 to that pin's capture bit fall in the same cycle, the capture bit stays set.
- R8: In an edge mode, irq is high exactly while the AND of the capture and mask (offset 0x08) registers is nonzero.
- R9: In level-high mode, irq is high exactly while the AND of the synchronised pins and the mask is nonzero, and the capture word reads as zero.
- R10: With HAS_SET_CLR=1, a write to offset 0x10 ORs the written value into the output register. A write to offset 0x14 clears the output bits that are written as 1. Both offsets read as zero.
- R11: With HAS_SET_CLR=0, writes to offsets 0x10 and 0x14 have no effect and both read as zero.
- R12: Writes whose address has either of its two low bits set are ignored. Register word index = bus_addr[4:2]. Indices 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | PIN_COUNT | Pad input levels |
| pin_out | output | PIN_COUNT | Output register |
| pin_oe | output | PIN_COUNT | Per-pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land on the same capture bit in one cycle: a freshly detected edge, which sets the bit, and a software write-1-to-clear, which clears it. A directed sequence places the clear write in the exact cycle in which the synchronised edge becomes visible, and then expects the bit to read back as set. Random traffic, which mixes capture clears with pin toggles, provokes the same collision on many pins. Each outcome is judged against a cycle-accurate bench model for four configurations: every trigger mode, several pin counts, and the set/clear option both present and absent.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int BUS_W      = 32;
    localparam int REG_ADDR_W = 5;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_mode_e;

    typedef enum logic [2:0] {
        IDX_DATA = 3'd0,
        IDX_DIR  = 3'd1,
        IDX_MASK = 3'd2,
        IDX_CAP  = 3'd3,
        IDX_SET  = 3'd4,
        IDX_CLR  = 3'd5
    } reg_idx_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] sync_q,
    output logic [W-1:0] prev_q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end
endmodule

// File: rtl/pio_capture.sv
module pio_capture
    import pio_pkg::*;
#(
    parameter int         W    = 32,
    parameter trig_mode_e MODE = TRIG_RISE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_q,
    input  logic [W-1:0] prev_q,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] cap_q
);
    generate
        if (MODE == TRIG_LEVEL) begin : g_none
            assign cap_q = '0;
        end else begin : g_edge
            logic [W-1:0] evt;
            logic [W-1:0] held;
            if (MODE == TRIG_RISE) begin : g_rise
                assign evt = sync_q & ~prev_q;
            end else if (MODE == TRIG_FALL) begin : g_fall
                assign evt = ~sync_q & prev_q;
            end else begin : g_both
                assign evt = sync_q ^ prev_q;
            end
            // a new edge overrides a same-cycle clear
            assign held = clr_we ? (cap_q & ~clr_mask) : cap_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cap_q <= '0;
                else        cap_q <= held | evt;
            end
        end
    endgenerate
endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int         PIN_COUNT   = 32,
    parameter trig_mode_e TRIG_MODE   = TRIG_RISE,
    parameter bit         HAS_SET_CLR = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_we,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    input  logic [PIN_COUNT-1:0]  pin_in,
    output logic [PIN_COUNT-1:0]  pin_out,
    output logic [PIN_COUNT-1:0]  pin_oe,
    output logic                  irq
);
    localparam int W = PIN_COUNT;

    logic [2:0]   idx;
    logic         aligned;
    logic [W-1:0] wd;
    logic [W-1:0] out_q, dir_q, mask_q;
    logic [W-1:0] sync_q, prev_q, cap_q;
    logic [W-1:0] rd_w;
    logic         wr_data, wr_dir, wr_mask, wr_cap, wr_set, wr_clr;

    assign idx     = bus_addr[REG_ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wd      = bus_wdata[W-1:0];

    assign wr_data = bus_we && aligned && (idx == IDX_DATA);
    assign wr_dir  = bus_we && aligned && (idx == IDX_DIR);
    assign wr_mask = bus_we && aligned && (idx == IDX_MASK);
    assign wr_cap  = bus_we && aligned && (idx == IDX_CAP);
    assign wr_set  = HAS_SET_CLR && bus_we && aligned && (idx == IDX_SET);
    assign wr_clr  = HAS_SET_CLR && bus_we && aligned && (idx == IDX_CLR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else begin
            if (wr_data)     out_q <= wd;
            else if (wr_set) out_q <= out_q | wd;
            else if (wr_clr) out_q <= out_q & ~wd;
            if (wr_dir)  dir_q  <= wd;
            if (wr_mask) mask_q <= wd;
        end
    end

    pio_sync #(.W(W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .sync_q (sync_q),
        .prev_q (prev_q)
    );

    pio_capture #(.W(W), .MODE(TRIG_MODE)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_q   (sync_q),
        .prev_q   (prev_q),
        .clr_we   (wr_cap),
        .clr_mask (wd),
        .cap_q    (cap_q)
    );

    generate
        if (TRIG_MODE == TRIG_LEVEL) begin : g_irq_level
            assign irq = |(sync_q & mask_q);
        end else begin : g_irq_edge
            assign irq = |(cap_q & mask_q);
        end
    endgenerate

    always_comb begin
        case (idx)
            IDX_DATA: rd_w = sync_q;
            IDX_DIR:  rd_w = dir_q;
            IDX_MASK: rd_w = mask_q;
            IDX_CAP:  rd_w = cap_q;
            default:  rd_w = '0;
        endcase
        bus_rdata         = '0;
        bus_rdata[W-1:0]  = rd_w;
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk
    import pio_pkg::*;
#(
    parameter int         W    = 32,
    parameter trig_mode_e MODE = TRIG_RISE,
    parameter bit         HSC  = 1'b1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic                  bus_we,
    input logic [BUS_W-1:0]      bus_wdata,
    input logic [W-1:0]          pin_out,
    input logic [W-1:0]          pin_oe,
    input logic                  irq,
    input logic [W-1:0]          cap,
    input logic [W-1:0]          sync,
    input logic [W-1:0]          prev
);
    logic wa;
    assign wa = bus_we && (bus_addr[1:0] == 2'b00);

    a_r2_out_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wa && bus_addr[4:2] == 3'd0) |=> (pin_out == $past(bus_wdata[W-1:0])));

    a_r3_oe_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wa && bus_addr[4:2] == 3'd1) |=> (pin_oe == $past(bus_wdata[W-1:0])));

    a_r5_cap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE != TRIG_LEVEL && !(wa && bus_addr[4:2] == 3'd3))
        |=> ((cap & $past(cap)) == $past(cap)));

    a_r6_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE != TRIG_LEVEL && wa && bus_addr[4:2] == 3'd3
         && bus_wdata[W-1:0] == {W{1'b1}} && sync == prev) |=> (cap == '0));

    a_r8_irq_needs_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE != TRIG_LEVEL && irq) |-> (cap != '0));

    a_r10_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (HSC && wa && bus_addr[4:2] == 3'd4)
        |=> ((pin_out & $past(bus_wdata[W-1:0])) == $past(bus_wdata[W-1:0])));
endmodule

bind pio_port pio_port_chk #(.W(PIN_COUNT), .MODE(TRIG_MODE), .HSC(HAS_SET_CLR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .cap       (cap_q),
    .sync      (sync_q),
    .prev      (prev_q)
);

// File: tb/pio_port_bench.sv
`timescale 1ns/1ps
module pio_port_bench;
    import pio_pkg::*;

    localparam int NI = 4;
    localparam int NP [NI] = '{32, 12, 8, 4};
    localparam int MD [NI] = '{0, 1, 3, 2};   // 0 rise,1 fall,2 both,3 level
    localparam bit HS [NI] = '{1'b1, 1'b0, 1'b1, 1'b1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] pins = '0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    logic [31:0] rd0, rd1, rd2, rd3;
    logic [31:0] po0, oe0;
    logic [11:0] po1, oe1;
    logic [7:0]  po2, oe2;
    logic [3:0]  po3, oe3;
    logic        irq0, irq1, irq2, irq3;

    pio_port u_pio_port (.clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wd), .bus_rdata(rd0), .pin_in(pins), .pin_out(po0),
        .pin_oe(oe0), .irq(irq0));
    pio_port #(.PIN_COUNT(12), .TRIG_MODE(TRIG_FALL), .HAS_SET_CLR(1'b0)) u_pio_fall (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wd),
        .bus_rdata(rd1), .pin_in(pins[11:0]), .pin_out(po1), .pin_oe(oe1), .irq(irq1));
    pio_port #(.PIN_COUNT(8), .TRIG_MODE(TRIG_LEVEL), .HAS_SET_CLR(1'b1)) u_pio_lvl (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wd),
        .bus_rdata(rd2), .pin_in(pins[7:0]), .pin_out(po2), .pin_oe(oe2), .irq(irq2));
    pio_port #(.PIN_COUNT(4), .TRIG_MODE(TRIG_BOTH), .HAS_SET_CLR(1'b1)) u_pio_both (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wd),
        .bus_rdata(rd3), .pin_in(pins[3:0]), .pin_out(po3), .pin_oe(oe3), .irq(irq3));

    logic [31:0] g_rd [NI];
    logic [31:0] g_out [NI];
    logic [31:0] g_oe [NI];
    logic        g_irq [NI];
    assign g_rd[0] = rd0; assign g_rd[1] = rd1; assign g_rd[2] = rd2; assign g_rd[3] = rd3;
    assign g_out[0] = po0;          assign g_oe[0] = oe0;
    assign g_out[1] = {20'b0, po1}; assign g_oe[1] = {20'b0, oe1};
    assign g_out[2] = {24'b0, po2}; assign g_oe[2] = {24'b0, oe2};
    assign g_out[3] = {28'b0, po3}; assign g_oe[3] = {28'b0, oe3};
    assign g_irq[0] = irq0; assign g_irq[1] = irq1; assign g_irq[2] = irq2; assign g_irq[3] = irq3;

    // reference model
    logic [31:0] m_s1 [NI], m_s2 [NI], m_p [NI];
    logic [31:0] m_out [NI], m_dir [NI], m_msk [NI], m_cap [NI];

    function automatic logic [31:0] wmask(int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    function automatic logic [31:0] edges(int i);
        case (MD[i])
            0: return m_s2[i] & ~m_p[i];
            1: return ~m_s2[i] & m_p[i];
            2: return m_s2[i] ^ m_p[i];
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NI; i++) begin
                m_s1[i] <= '0; m_s2[i] <= '0; m_p[i] <= '0;
                m_out[i] <= '0; m_dir[i] <= '0; m_msk[i] <= '0; m_cap[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NI; i++) begin
                logic [31:0] m;
                logic        ok;
                logic [2:0]  ix;
                m  = wmask(NP[i]);
                ok = we && (addr[1:0] == 2'b00);
                ix = addr[4:2];
                m_s1[i] <= pins & m;
                m_s2[i] <= m_s1[i];
                m_p[i]  <= m_s2[i];
                if (ok && ix == 3'd0)               m_out[i] <= wd & m;
                else if (ok && ix == 3'd4 && HS[i]) m_out[i] <= m_out[i] | (wd & m);
                else if (ok && ix == 3'd5 && HS[i]) m_out[i] <= m_out[i] & ~wd & m;
                if (ok && ix == 3'd1) m_dir[i] <= wd & m;
                if (ok && ix == 3'd2) m_msk[i] <= wd & m;
                if (MD[i] != 3)
                    m_cap[i] <= ((ok && ix == 3'd3) ? (m_cap[i] & ~wd) : m_cap[i]) | edges(i);
            end
        end
    end

    function automatic logic [31:0] exp_rd(int i);
        case (addr[4:2])
            3'd0: return m_s2[i];
            3'd1: return m_dir[i];
            3'd2: return m_msk[i];
            3'd3: return m_cap[i];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(int i);
        case (addr[4:2])
            3'd0: return "R2";
            3'd1: return "R3";
            3'd3: return "R5";
            3'd4, 3'd5: return HS[i] ? "R10" : "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        for (int i = 0; i < NI; i++) begin
            chk(rd_tag(i), g_rd[i], exp_rd(i));
            chk("R2", g_out[i], m_out[i]);
            chk("R3", g_oe[i], m_dir[i]);
            chk(MD[i] == 3 ? "R9" : "R8", {31'b0, g_irq[i]},
                {31'b0, (MD[i] == 3) ? |(m_s2[i] & m_msk[i]) : |(m_cap[i] & m_msk[i])});
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        addr = a; wd = d; we = 1'b1;
        tick();
        we = 1'b0;
    endtask

    task automatic rd_at(logic [4:0] a);
        addr = a;
        #0.5;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1: reset state
        rd_at(5'h04); chk("R1", rd0, 32'h0);
        rd_at(5'h08); chk("R1", rd0, 32'h0);
        rd_at(5'h0C); chk("R1", rd0, 32'h0);
        chk("R1", po0, 32'h0); chk("R1", oe0, 32'h0); chk("R1", {31'b0, irq0}, 32'h0);

        // R10 / R11: set and clear words
        wr(5'h00, 32'h0F0);
        wr(5'h10, 32'h003);
        chk("R10", po0, 32'h0F3);
        chk("R11", {20'b0, po1}, 32'h0F0);
        wr(5'h14, 32'h030);
        chk("R10", po0, 32'h0C3);
        rd_at(5'h10); chk("R10", rd0, 32'h0); chk("R11", rd1, 32'h0);
        rd_at(5'h14); chk("R10", rd0, 32'h0);

        // R12: misaligned write ignored; R3/R4: direction and width
        wr(5'h05, 32'hFFFF_FFFF);
        rd_at(5'h04); chk("R12", rd0, 32'h0);
        wr(5'h04, 32'hFFFF_FFFF);
        rd_at(5'h04); chk("R4", rd1, 32'h0000_0FFF); chk("R3", oe0, 32'hFFFF_FFFF);
        rd_at(5'h18); chk("R12", rd0, 32'h0);

        // R7: edge and clear in the same cycle
        pins = '0;
        repeat (4) tick();
        wr(5'h0C, 32'hFFFF_FFFF);
        pins[0] = 1'b1;
        tick();
        tick();
        wr(5'h0C, 32'h1);
        rd_at(5'h0C); chk("R7", rd0 & 32'h1, 32'h1);
        wr(5'h0C, 32'h1);
        rd_at(5'h0C); chk("R6", rd0 & 32'h1, 32'h0);

        // R5 / R6 / R8: capture, write-zero, masked irq
        pins[1] = 1'b1;
        repeat (3) tick();
        rd_at(5'h0C); chk("R5", rd0 & 32'h2, 32'h2); chk("R5", rd1 & 32'h2, 32'h0);
        wr(5'h0C, 32'h0);
        rd_at(5'h0C); chk("R6", rd0 & 32'h2, 32'h2);
        wr(5'h08, 32'h2);
        chk("R8", {31'b0, irq0}, 32'h1);
        wr(5'h0C, 32'h2);
        chk("R8", {31'b0, irq0}, 32'h0);

        // R5 falling mode on the 12-pin port
        pins[2] = 1'b1;
        repeat (4) tick();
        pins[2] = 1'b0;
        repeat (3) tick();
        rd_at(5'h0C); chk("R5", rd1 & 32'h4, 32'h4);

        // R9: level-high port
        wr(5'h08, 32'h4);
        pins[2] = 1'b1;
        tick();
        chk("R9", {31'b0, irq2}, 32'h0);
        tick();
        chk("R9", {31'b0, irq2}, 32'h1);
        rd_at(5'h0C); chk("R9", rd2, 32'h0);

        // constrained random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            we = ($urandom % 3) == 0;
            if (($urandom % 8) != 0) addr = {3'($urandom % 6), 2'b00};
            else                     addr = 5'($urandom);
            wd = (($urandom % 4) == 0) ? 32'hFFFF_FFFF : $urandom;
            if (($urandom % 3) == 0) pins = pins ^ (32'h1 << ($urandom % 32));
            tick();
        end
        we = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule